// File: doc/BRIEF.md
# Masked Set/Clear General-Purpose Output Port

This block is a memory-mapped general-purpose I/O port, 32 pins wide by default. Software drives it through a single-cycle register interface with a word address, a write enable, per-byte write strobes, write data and combinational read data. The pins are updated in one of two ways. The first is write-only set and clear words. These act only on bits written as 1, so software never has to read the port before changing a pin. The second is a direct pin-value word that assigns ones and zeros in the same cycle. A protect mask filters that word so that marked pins keep their state.

A direction word drives the per-pin output enables. The output latch keeps its value while a pin is configured as input, so the pin comes back with its old level when it is turned into an output again. Reading the pin-value word returns the pad input levels with protected pins forced to 0. Every write strobe covers one byte lane, so software can update any single byte of the port without a read-modify-write.

Register word addresses: 0 pin value, 1 set, 2 clear, 3 protect mask, 4 direction. Every other address reads as 0 and ignores writes.

Top module: `gpio_setclr_port`

## Requirements
- R1: While reset is held, and after it is released, the output latch, the direction word and the protect mask are all 0, so pad_out and pad_oe are 0.
- R2: A write to word 1 (set) drives high every pin whose bit is 1 in an enabled byte lane. All such pins change on the same clock edge, and no pin is ever driven low by this write.
- R3: A write to word 2 (clear) drives low every pin whose bit is 1 in an enabled byte lane, and no pin is ever driven high by this write.
- R4: A write to word 0 (pin value) loads each unprotected pin of an enabled lane with its write-data bit, ones and zeros together on one edge.
- R5: Pins whose protect-mask bit (word 3) is 1 are unchanged by a pin-value write.
- R6: Byte strobe k enables bits 8k+7..8k. Bits in lanes whose strobe is 0 are unaffected by a write to any word.
- R7: The protect mask has no effect on set and clear writes.
- R8: Reading word 0 returns pad_in AND NOT mask, so protected pins read as 0.
- R9: Word 1 reads back the output latch, word 2 reads 0, words 3 and 4 read back the mask and the direction, and unmapped words read 0 and ignore writes.
- R10: pad_oe follows the direction word (1 = output). pad_out always shows the output latch, which is kept and updated while the pin is an input.
- R11: A write takes effect at the clock edge that samples it. With no write, the pad outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Word address |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte lane strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Output latch value |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
A wrong latch or mask bit appears on pad_out, or in the word 0 or word 1 readback, one cycle after the write that should have set it. Every write therefore has to be compared at once with a model of the latch, protect mask and direction word. Set and clear writes are swept over single bits and mixed patterns. Pin-value writes are swept over all strobe combinations and mask patterns, so that a lane or mask decode fault shows up as a flipped pin on the next edge. Pseudo-random sequences that mix all five words catch state that goes wrong only after several operations.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    REG_PIN  = 3'd0,
    REG_SET  = 3'd1,
    REG_CLR  = 3'd2,
    REG_MASK = 3'd3,
    REG_DIR  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_q
);
  logic [1:0] stage_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end
  assign rst_n_q = stage_q[1];
endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned LANES = WIDTH / 8
) (
  input  logic [gpio_pkg::ADDR_W-1:0] addr,
  input  logic                        we,
  input  logic [LANES-1:0]            be,
  output logic                        wr_pin,
  output logic                        wr_set,
  output logic                        wr_clr,
  output logic                        wr_mask,
  output logic                        wr_dir,
  output logic [WIDTH-1:0]            lane_bits
);
  import gpio_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bits[g*8 +: 8] = {8{be[g]}};
  end

  always_comb begin
    wr_pin  = we && (addr == REG_PIN);
    wr_set  = we && (addr == REG_SET);
    wr_clr  = we && (addr == REG_CLR);
    wr_mask = we && (addr == REG_MASK);
    wr_dir  = we && (addr == REG_DIR);
  end
endmodule

// File: rtl/gpio_field_reg.sv
module gpio_field_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] lane_bits,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] value_q
);
  logic [WIDTH-1:0] value_d;
  logic             load;

  always_comb begin
    load    = wr_en && (|lane_bits);
    value_d = (value_q & ~lane_bits) | (wdata & lane_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value_q <= '0;
    else if (load) value_q <= value_d;
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_pin,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [WIDTH-1:0] lane_bits,
  input  logic [WIDTH-1:0] protect,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q
);
  logic [WIDTH-1:0] rise_v, fall_v, load_en, latch_d;
  logic             upd;

  always_comb begin
    rise_v  = wr_set ? (wdata & lane_bits) : '0;
    fall_v  = wr_clr ? (wdata & lane_bits) : '0;
    load_en = wr_pin ? (lane_bits & ~protect) : '0;
    // clear wins over set and load on any shared bit
    latch_d = (((latch_q & ~load_en) | (wdata & load_en)) | rise_v) & ~fall_v;
    upd     = wr_pin || wr_set || wr_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   latch_q <= '0;
    else if (upd) latch_q <= latch_d;
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [gpio_pkg::ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]            pad_in,
  input  logic [WIDTH-1:0]            latch_q,
  input  logic [WIDTH-1:0]            mask_q,
  input  logic [WIDTH-1:0]            dir_q,
  output logic [WIDTH-1:0]            rdata
);
  import gpio_pkg::*;
  always_comb begin
    case (addr)
      REG_PIN:  rdata = pad_in & ~mask_q;
      REG_SET:  rdata = latch_q;
      REG_MASK: rdata = mask_q;
      REG_DIR:  rdata = dir_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned LANES = WIDTH / 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [gpio_pkg::ADDR_W-1:0] bus_addr,
  input  logic                        bus_we,
  input  logic [LANES-1:0]            bus_be,
  input  logic [WIDTH-1:0]            bus_wdata,
  output logic [WIDTH-1:0]            bus_rdata,
  input  logic [WIDTH-1:0]            pad_in,
  output logic [WIDTH-1:0]            pad_out,
  output logic [WIDTH-1:0]            pad_oe
);
  logic             rst_n_q;
  logic             wr_pin, wr_set, wr_clr, wr_mask, wr_dir;
  logic [WIDTH-1:0] lane_bits, mask_q, dir_q, latch_q;

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_q(rst_n_q));

  gpio_bus_decode #(.WIDTH(WIDTH)) u_dec (
    .addr(bus_addr), .we(bus_we), .be(bus_be),
    .wr_pin(wr_pin), .wr_set(wr_set), .wr_clr(wr_clr),
    .wr_mask(wr_mask), .wr_dir(wr_dir), .lane_bits(lane_bits)
  );

  gpio_field_reg #(.WIDTH(WIDTH)) u_mask (
    .clk(clk), .rst_n(rst_n_q), .wr_en(wr_mask),
    .lane_bits(lane_bits), .wdata(bus_wdata), .value_q(mask_q)
  );

  gpio_field_reg #(.WIDTH(WIDTH)) u_dir (
    .clk(clk), .rst_n(rst_n_q), .wr_en(wr_dir),
    .lane_bits(lane_bits), .wdata(bus_wdata), .value_q(dir_q)
  );

  gpio_out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n_q), .wr_pin(wr_pin), .wr_set(wr_set),
    .wr_clr(wr_clr), .lane_bits(lane_bits), .protect(mask_q),
    .wdata(bus_wdata), .latch_q(latch_q)
  );

  gpio_read_mux #(.WIDTH(WIDTH)) u_rd (
    .addr(bus_addr), .pad_in(pad_in), .latch_q(latch_q),
    .mask_q(mask_q), .dir_q(dir_q), .rdata(bus_rdata)
  );

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_setclr_chk.sv
module gpio_setclr_chk #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned LANES = WIDTH / 8
) (
  input logic                        clk,
  input logic                        rst_n_q,
  input logic [gpio_pkg::ADDR_W-1:0] bus_addr,
  input logic                        bus_we,
  input logic [LANES-1:0]            bus_be,
  input logic [WIDTH-1:0]            bus_wdata,
  input logic [WIDTH-1:0]            bus_rdata,
  input logic [WIDTH-1:0]            pad_out,
  input logic [WIDTH-1:0]            pad_oe,
  input logic [WIDTH-1:0]            mask_q
);
  import gpio_pkg::*;
  logic [WIDTH-1:0] lanes;
  always_comb begin
    for (int k = 0; k < WIDTH; k++) lanes[k] = bus_be[k/8];
  end

  AST_SET_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n_q)
    (bus_we && bus_addr == REG_SET) |=> ((pad_out & $past(pad_out)) == $past(pad_out))); // R2
  AST_CLR_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n_q)
    (bus_we && bus_addr == REG_CLR) |=> ((pad_out & ~$past(pad_out)) == '0)); // R3
  AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_q)
    (bus_we && bus_addr == REG_PIN) |=> (((pad_out ^ $past(pad_out)) & $past(mask_q)) == '0)); // R5
  AST_LANE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n_q)
    bus_we |=> (((pad_out ^ $past(pad_out)) & ~$past(lanes)) == '0)); // R6
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n_q)
    (bus_addr == REG_CLR) |-> (bus_rdata == '0)); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n_q)
    !bus_we |=> ($stable(pad_out) && $stable(pad_oe))); // R11
endmodule

bind gpio_setclr_port gpio_setclr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n_q(rst_n_q), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .mask_q(mask_q)
);

// File: tb/gpio_setclr_port_tb.sv
module gpio_setclr_port_tb;
  localparam int W = 16;
  localparam int L = W / 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [L-1:0] bus_be = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata, pad_in = '0, pad_out, pad_oe;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [W-1:0] m_out = '0, m_mask = '0, m_dir = '0;
  logic [31:0]  rng = 32'h1234_5678;

  always #4 clk = ~clk;

  gpio_setclr_port #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [W-1:0] lanes_of(input logic [L-1:0] be);
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) r[k] = be[k/8];
    return r;
  endfunction

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model update from the requirements, then one bus write
  task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input logic [L-1:0] be);
    logic [W-1:0] ln = lanes_of(be);
    case (a)
      3'd0: m_out = (m_out & ~(ln & ~m_mask)) | (d & ln & ~m_mask);
      3'd1: m_out = m_out | (d & ln);
      3'd2: m_out = m_out & ~(d & ln);
      3'd3: m_mask = (m_mask & ~ln) | (d & ln);
      3'd4: m_dir = (m_dir & ~ln) | (d & ln);
      default: ;
    endcase
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    #1;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [W-1:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pads(input string tag);
    chk(tag, pad_out, m_out);
    chk({tag, " oe"}, pad_oe, m_dir);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out in reset", pad_out, '0);
    chk("R1 oe in reset", pad_oe, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    pads("R1 after release");
    rd("R1 mask", 3'd3, '0);

    // R2 / R3 single-bit walk
    for (int i = 0; i < W; i++) begin
      wr(3'd1, W'(1) << i, '1); pads("R2 single set");
    end
    for (int i = 0; i < W; i += 2) begin
      wr(3'd2, W'(1) << i, '1); pads("R3 single clear");
    end
    wr(3'd1, 16'h8421, '1); pads("R2 multi set same edge");
    wr(3'd2, 16'hF0F0, '1); pads("R3 multi clear");

    // R4 / R5 / R6 pin writes over all strobe and a sweep of masks
    for (int mk = 0; mk < 16; mk++) begin
      wr(3'd3, {4{mk[3:0]}} ^ 16'h0F30, '1);
      for (int be = 0; be < (1 << L); be++) begin
        rng = next_rng(rng);
        wr(3'd0, rng[W-1:0], L'(be));
        pads("R4 R5 R6 pin write");
        rd("R9 set readback", 3'd1, m_out);
      end
    end
    wr(3'd3, '1, '1);
    wr(3'd0, ~m_out, '1); pads("R5 all protected");

    // R7 mask ignored by set/clear
    wr(3'd1, '1, '1); pads("R7 set under full mask");
    wr(3'd2, 16'h00FF, 2'b01); pads("R7 clear under full mask");

    // R8 pin readback
    for (int p = 0; p < 32; p++) begin
      rng = next_rng(rng);
      pad_in = rng[W-1:0];
      wr(3'd3, rng[31:16], '1);
      rd("R8 pin read", 3'd0, pad_in & ~m_mask);
    end

    // R9 readbacks and unmapped
    rd("R9 clear reads zero", 3'd2, '0);
    rd("R9 mask read", 3'd3, m_mask);
    wr(3'd6, '1, '1); pads("R9 unmapped write ignored");
    rd("R9 unmapped read", 3'd6, '0);

    // R10 latch kept while input
    wr(3'd4, '0, '1);
    wr(3'd3, '0, '1);
    wr(3'd0, 16'hA5C3, '1); pads("R10 latch updated as input");
    wr(3'd4, 16'hFF00, 2'b10); pads("R10 oe upper lane");
    rd("R10 dir read", 3'd4, m_dir);

    // R11 idle hold
    repeat (5) @(negedge clk);
    #1; pads("R11 idle hold");

    // mixed random sequence
    for (int n = 0; n < 400; n++) begin
      logic [2:0] a;
      rng = next_rng(rng);
      a = 3'(rng[2:0] % 5);
      wr(a, rng[23:8], L'(rng[25:24]));
      pads("R2 R3 R4 R6 mixed");
      rd("R9 mixed set read", 3'd1, m_out);
      rd("R9 mixed mask read", 3'd3, m_mask);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule